// File: doc/BRIEF.md
# Shared Physical Register Release Tracker

This block keeps one small use counter per physical register of a renaming core, so that an eliminated register move can let two architectural names point at the same physical register. Each cycle, rename reports up to two new references (a register taken as a fresh destination, or a source reused as the destination of a removed move). Retirement reports up to two dropped references (an old mapping overwritten and then retired). A register leaves circulation while any reference holds it. It becomes free again only when the last reference goes away.

Free registers sit in a circular queue. The queue starts out holding every register above the architectural range in ascending order. Rename asks for zero, one or two registers per cycle from the head of this queue. Registers whose counter reaches zero are appended at the tail on the following clock edge.

Top module: `refcount_freelist`

## Requirements
- R1: After reset, registers 0 to ARCH_REGS-1 hold one reference each and are not free. The queue holds ARCH_REGS to NUM_PREGS-1 in ascending order, so `free_count` is NUM_PREGS-ARCH_REGS, `pop_idx[0]` is ARCH_REGS and `pop_idx[1]` is ARCH_REGS+1.
- R2: Each valid `alloc_vld[k]` lane adds one to the counter of register `alloc_idx[k]`. A register that was referenced twice needs two releases before it is freed.
- R3: Each valid `rel_vld[k]` lane subtracts one from the counter of register `rel_idx[k]`. A register is appended to the queue only when its counter goes from a nonzero value to zero. With no release lane valid, nothing is appended.
- R4: All references and releases aimed at one register in the same cycle are combined into a single net change. An add and a drop on the same register in one cycle leave its count unchanged, and the register is not freed.
- R5: `pop_num` (0, 1 or 2; 3 is not allowed) is the number of registers requested. When `free_count` >= `pop_num`, `pop_ok` is 1 and the head advances by `pop_num` at the clock edge. `pop_idx[0]` and `pop_idx[1]` always show the first two queue entries, oldest first.
- R6: When `free_count` < `pop_num`, `pop_ok` is 0 and the head does not move.
- R7: Registers freed in a cycle are appended on that clock edge, two at most, lower index first. `free_count` becomes the old count, plus the number appended, minus the number popped.
- R8: Two release lanes naming the same register in one cycle drop two references, and free that register at most once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_vld | input | 2 | Per-lane reference add valid |
| alloc_idx | input | 2x7 | Per-lane register receiving a reference |
| rel_vld | input | 2 | Per-lane reference drop valid |
| rel_idx | input | 2x7 | Per-lane register losing a reference |
| pop_num | input | 2 | Number of free registers requested (0..2) |
| pop_ok | output | 1 | Request granted this cycle |
| pop_idx | output | 2x7 | First two free registers, oldest in lane 0 |
| free_count | output | 8 | Number of registers in the free queue |

## Verification
On every cycle the assertions check the following:
- the queue occupancy never exceeds the register count;
- occupancy grows by at most two per cycle;
- occupancy never grows in a cycle without a valid release lane;
- a granted request with no releases lowers occupancy by exactly the number requested;
- a refused request leaves the queue head unchanged.

Other behaviours show only in the bench's scenarios, which compare every output against a behavioural model on each cycle:
- the net combining of a same-cycle add and drop;
- the two-references-then-free sequence;
- lower-index-first ordering of a pair of releases;
- single freeing under duplicate release lanes;
- the exact reset contents of the queue.

// File: rtl/refcount_freelist.sv
module refcount_freelist #(
  parameter int NUM_PREGS = 128,
  parameter int ARCH_REGS = 32,
  parameter int CNT_W     = 4,
  localparam int PW = $clog2(NUM_PREGS),
  localparam int FW = PW + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           alloc_vld,
  input  logic [1:0][PW-1:0]   alloc_idx,
  input  logic [1:0]           rel_vld,
  input  logic [1:0][PW-1:0]   rel_idx,
  input  logic [1:0]           pop_num,
  output logic                 pop_ok,
  output logic [1:0][PW-1:0]   pop_idx,
  output logic [FW-1:0]        free_count
);

  logic [CNT_W-1:0]   cnt    [NUM_PREGS];
  logic [CNT_W-1:0]   cnt_nx [NUM_PREGS];
  logic [NUM_PREGS-1:0] hit_zero;

  for (genvar g = 0; g < NUM_PREGS; g++) begin : g_reg
    localparam logic [CNT_W-1:0] INIT = (g < ARCH_REGS) ? CNT_W'(1) : '0;
    logic [CNT_W-1:0] up, dn;
    assign up = CNT_W'(alloc_vld[0] && alloc_idx[0] == PW'(g))
              + CNT_W'(alloc_vld[1] && alloc_idx[1] == PW'(g));
    assign dn = CNT_W'(rel_vld[0] && rel_idx[0] == PW'(g))
              + CNT_W'(rel_vld[1] && rel_idx[1] == PW'(g));
    assign cnt_nx[g]   = cnt[g] + up - dn;
    assign hit_zero[g] = (cnt[g] != '0) && (cnt_nx[g] == '0);
    always_ff @(posedge clk) begin
      if (!rst_n) cnt[g] <= INIT;
      else        cnt[g] <= cnt_nx[g];
    end
  end

  logic          c0, c1, both;
  logic [PW-1:0] lo, hi;
  logic [FW-1:0] n_push, n_pop, fcnt;
  logic [PW-1:0] head, tail;
  logic [PW-1:0] fl [NUM_PREGS];

  assign c0   = rel_vld[0] && hit_zero[rel_idx[0]];
  assign c1   = rel_vld[1] && hit_zero[rel_idx[1]] &&
                !(rel_vld[0] && rel_idx[0] == rel_idx[1]);
  assign both = c0 && c1;
  assign lo   = both ? ((rel_idx[0] < rel_idx[1]) ? rel_idx[0] : rel_idx[1])
                     : (c0 ? rel_idx[0] : rel_idx[1]);
  assign hi   = (rel_idx[0] < rel_idx[1]) ? rel_idx[1] : rel_idx[0];

  assign n_push = FW'(c0) + FW'(c1);
  assign pop_ok = fcnt >= FW'(pop_num);
  assign n_pop  = pop_ok ? FW'(pop_num) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_PREGS; i++)
        fl[i] <= PW'((i + ARCH_REGS) % NUM_PREGS);
      head <= '0;
      tail <= PW'(NUM_PREGS - ARCH_REGS);
      fcnt <= FW'(NUM_PREGS - ARCH_REGS);
    end else begin
      if (c0 || c1) fl[tail] <= lo;
      if (both)     fl[tail + PW'(1)] <= hi;
      tail <= tail + PW'(n_push);
      head <= head + PW'(n_pop);
      fcnt <= fcnt + n_push - n_pop;
    end
  end

  assign pop_idx[0] = fl[head];
  assign pop_idx[1] = fl[head + PW'(1)];
  assign free_count = fcnt;

endmodule

// File: rtl/refcount_freelist_chk.sv
module refcount_freelist_chk #(
  parameter int NUM_PREGS = 128,
  localparam int PW = $clog2(NUM_PREGS),
  localparam int FW = PW + 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic [1:0]         rel_vld,
  input logic [1:0]         pop_num,
  input logic               pop_ok,
  input logic [1:0][PW-1:0] pop_idx,
  input logic [FW-1:0]      free_count
);

  assert_pop_num_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pop_num != 2'd3);

  assert_pop_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_ok && rel_vld == 2'b00) |=>
      free_count == $past(free_count) - FW'($past(pop_num)));

  assert_stall_holds_head_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_num != 2'd0 && !pop_ok && free_count != '0) |=> $stable(pop_idx[0]));

  assert_no_release_without_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_vld == 2'b00) |=> free_count <= $past(free_count));

  assert_push_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> free_count <= $past(free_count) + FW'(2));

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    free_count <= FW'(NUM_PREGS));

endmodule

bind refcount_freelist refcount_freelist_chk #(.NUM_PREGS(NUM_PREGS)) u_chk (
  .clk(clk), .rst_n(rst_n), .rel_vld(rel_vld), .pop_num(pop_num),
  .pop_ok(pop_ok), .pop_idx(pop_idx), .free_count(free_count)
);

// File: tb/refcount_freelist_test.sv
`timescale 1ns/1ps
module refcount_freelist_test;
  localparam int NP = 128;
  localparam int AR = 32;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [1:0]      alloc_vld, rel_vld, pop_num;
  logic [1:0][6:0] alloc_idx, rel_idx, pop_idx;
  logic            pop_ok;
  logic [7:0]      free_count;

  int checks = 0, errors = 0;
  int mcnt[NP];
  int mq[$];
  int owned[$];
  bit done = 0;

  always #2.5 clk = ~clk;

  refcount_freelist uut (
    .clk(clk), .rst_n(rst_n), .alloc_vld(alloc_vld), .alloc_idx(alloc_idx),
    .rel_vld(rel_vld), .rel_idx(rel_idx), .pop_num(pop_num), .pop_ok(pop_ok),
    .pop_idx(pop_idx), .free_count(free_count)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic cyc(input bit a0v, input int a0, input bit a1v, input int a1,
                     input bit d0v, input int d0, input bit d1v, input int d1,
                     input int pn, input string tag);
    int old[NP];
    bit eok;
    alloc_vld = {a1v, a0v};
    alloc_idx[0] = 7'(a0); alloc_idx[1] = 7'(a1);
    rel_vld = {d1v, d0v};
    rel_idx[0] = 7'(d0); rel_idx[1] = 7'(d1);
    pop_num = 2'(pn);
    #1;
    eok = mq.size() >= pn;
    chk(int'(free_count) == mq.size(), tag, "free_count", int'(free_count), mq.size());
    chk(pop_ok == eok, tag, "pop_ok", int'(pop_ok), int'(eok));
    if (mq.size() >= 1) chk(int'(pop_idx[0]) == mq[0], tag, "pop_idx0", int'(pop_idx[0]), mq[0]);
    if (mq.size() >= 2) chk(int'(pop_idx[1]) == mq[1], tag, "pop_idx1", int'(pop_idx[1]), mq[1]);
    for (int r = 0; r < NP; r++) old[r] = mcnt[r];
    if (eok) repeat (pn) void'(mq.pop_front());
    if (a0v) mcnt[a0]++;
    if (a1v) mcnt[a1]++;
    if (d0v) mcnt[d0]--;
    if (d1v) mcnt[d1]--;
    for (int r = 0; r < NP; r++)
      if (old[r] != 0 && mcnt[r] == 0) mq.push_back(r);
    @(posedge clk);
    #1;
  endtask

  task automatic idle(input string tag);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    int x;
    rst_n = 1'b0;
    alloc_vld = '0; alloc_idx = '0; rel_vld = '0; rel_idx = '0; pop_num = '0;
    for (int r = 0; r < NP; r++) mcnt[r] = (r < AR) ? 1 : 0;
    for (int r = AR; r < NP; r++) mq.push_back(r);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    idle("R1");
    cyc(0, 0, 0, 0, 1, 5, 0, 0, 0, "R1");
    idle("R3");

    cyc(0, 0, 0, 0, 0, 0, 0, 0, 2, "R5");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, "R5");

    x = mq[0];
    cyc(1, x, 0, 0, 0, 0, 0, 0, 1, "R2");
    cyc(0, 0, 1, x, 0, 0, 0, 0, 0, "R2");
    cyc(0, 0, 0, 0, 1, x, 0, 0, 0, "R2");
    idle("R2");
    cyc(0, 0, 0, 0, 0, 0, 1, x, 0, "R2");
    idle("R3");

    cyc(1, 7, 0, 0, 0, 0, 1, 7, 0, "R4");
    idle("R4");
    cyc(0, 0, 0, 0, 1, 7, 0, 0, 0, "R4");

    cyc(1, 3, 0, 0, 0, 0, 0, 0, 0, "R8");
    cyc(0, 0, 0, 0, 1, 3, 1, 3, 0, "R8");
    idle("R8");

    cyc(0, 0, 0, 0, 1, 20, 1, 10, 2, "R7");
    cyc(0, 0, 0, 0, 1, 11, 1, 12, 1, "R7");

    while (mq.size() >= 2) cyc(0, 0, 0, 0, 0, 0, 0, 0, 2, "R5");
    if (mq.size() == 0) cyc(0, 0, 0, 0, 1, 9, 0, 0, 0, "R3");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 2, "R6");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 2, "R6");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, "R5");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, "R6");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 2, "R6");

    for (int r = 0; r < NP; r++)
      for (int k = 0; k < mcnt[r]; k++) owned.push_back(r);
    for (int i = 0; i < 300; i++) begin
      int pn, a0, a1, d0, d1;
      bit a0v, a1v, d0v, d1v;
      pn = (mq.size() >= 2) ? 2 : mq.size();
      if (i % 7 == 3) pn = 0;
      a0v = pn >= 1; a0 = a0v ? mq[0] : 0;
      a1v = pn >= 2; a1 = a1v ? mq[1] : 0;
      if (!a1v && owned.size() > 0 && mcnt[owned[owned.size()-1]] < 8) begin
        a1v = 1; a1 = owned[owned.size()-1];
      end
      d0v = owned.size() > 20 && (i % 3 != 0);
      d0 = d0v ? owned.pop_front() : 0;
      d1v = owned.size() > 20 && (i % 5 != 1);
      d1 = d1v ? owned.pop_front() : 0;
      cyc(a0v, a0, a1v, a1, d0v, d0, d1v, d1, pn, "R7");
      if (a0v) owned.push_back(a0);
      if (a1v) owned.push_back(a1);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule